// File: doc/BRIEF.md
# Programmable-Baud Serial Peripheral Master

This block is the master side of a four-wire serial link. It derives a serial clock from the fast system clock through a programmable baud value. It then shifts one word of 1 to 16 bits out on the serial data output, most significant bit first, while it captures the same number of bits from the serial data input. A polarity bit sets the idle level of the serial clock. A phase-mode bit picks one of two timings. In immediate timing, the first bit is launched together with the first clock edge. In delayed timing, each bit is launched half a serial period before the edge that samples it. Odd divisors cannot split evenly, so they give a period whose halves differ by one system cycle.

A transfer is requested on a valid/ready input stream that carries the transmit word. The request is taken on a cycle where `tx_valid` and `tx_ready` are both high. `tx_ready` is low for the whole transfer, so an upstream source that holds `tx_valid` simply waits, and its word stays unconsumed until the block is idle again. The baud value, polarity, phase mode and length are sampled on that same cycle and used for the whole transfer. The received word leaves on a valid-only stream. `rx_valid` pulses for one cycle and has no back-pressure, so the consumer must take the word in that cycle. `rx_data` keeps the word until the next transfer completes.

Top module: `spi_baud_master`

## Requirements
- R1: The serial period N in system cycles is `cfg_baud + 1` for baud values 3 to 127, and exactly 4 for baud values 0, 1 and 2.
- R2: For an even N, the serial clock spends N/2 cycles at its non-idle level and N/2 cycles at its idle level in every bit period.
- R3: For an odd N, the non-idle level lasts (N-1)/2 cycles and the idle level lasts (N+1)/2 cycles. With polarity 0 the high phase is therefore the shorter one, and with polarity 1 the low phase is.
- R4: While no transfer runs, `sclk` equals `cfg_cpol`, following a change one cycle later. The first edge of each bit period (the leading edge) is rising for polarity 0 and falling for polarity 1.
- R5: With `cfg_delayed` = 0, each bit period starts with the leading edge, and `mosi` shows its bit from that edge for the whole period. `miso` is captured at the system edge that returns `sclk` to idle, which ends cycle (N/2 rounded down) - 1 of the period.
- R6: With `cfg_delayed` = 1, each bit period starts with (N+1)/2 rounded-down-of-(N+1)/2, i.e. ceil(N/2), idle-level cycles during which the bit is already on `mosi`. `miso` is captured on the leading edge that follows, which ends cycle ceil(N/2) - 1 of the period. The bit stays on `mosi` for the floor(N/2) cycles after that edge, and `sclk` returns to idle at the end of the period.
- R7: A `cfg_len` value v (4-bit field) selects v+1 bits. `tx_data[v]` is sent first and `tx_data[0]` last. The first received bit lands in `rx_data[v]` and the last in `rx_data[0]`. Bits above v in `rx_data` are zero.
- R8: `tx_ready` is the inverse of `busy`. A request is accepted on a cycle where `tx_valid` and `tx_ready` are both high. `busy` is then high from the next cycle for exactly (v+1)*N cycles. `tx_valid` while busy starts nothing, and `mosi` is 0 while idle.
- R9: In the first cycle after `busy` falls, `rx_valid` is high for exactly one cycle, `rx_data` holds the received word and `sclk` is back at its idle level. `rx_data` keeps that word until the next completion.
- R10: Changes on `cfg_baud`, `cfg_cpol`, `cfg_delayed` and `cfg_len` after acceptance do not change the clock, data or length of the running transfer.
- R11: During and right after reset, `busy`, `sclk`, `mosi`, `rx_valid` and `rx_data` are 0 and `tx_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_baud | input | BAUD_W | Baud value selecting the serial period |
| cfg_cpol | input | 1 | Serial clock idle level and leading-edge direction |
| cfg_delayed | input | 1 | 1 selects delayed timing, 0 immediate timing |
| cfg_len | input | LEN_W | Word length minus one |
| tx_valid | input | 1 | Transfer request with a valid transmit word |
| tx_ready | output | 1 | Block is idle and will accept a request |
| tx_data | input | DATA_W | Transmit word, right-justified |
| rx_valid | output | 1 | One-cycle pulse: received word is complete |
| rx_data | output | DATA_W | Received word, right-justified |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data output |
| miso | input | 1 | Serial data input |

## Verification
Assertions check, on every cycle, several timing rules. The serial clock changes only at the period start or at the mid-period split point. While idle it follows the polarity input one cycle later. A request is only taken from an asserted `tx_valid`. The completion pulse is a single cycle right after `busy` falls, with nothing set above the selected length. Only the bench's sweeps can show the rest, because it depends on the exact period arithmetic. Across every baud value, both polarities, both timings and all lengths, the bench compares the whole `sclk`, `mosi` and `busy` waveforms cycle by cycle with values computed from N. It drives `miso` to the wanted bit only in the single cycle before the capture edge and to its complement elsewhere, so any shift of the capture point shows up in `rx_data`. It also scrambles the configuration mid-transfer and holds `tx_valid` while busy.

// File: rtl/spi_bm_pkg.sv
package spi_bm_pkg;
  typedef enum logic {
    PH_IMMEDIATE = 1'b0,
    PH_DELAYED   = 1'b1
  } phase_mode_e;

  localparam int unsigned MIN_DIV          = 4;
  localparam int unsigned FIXED_BAUD_LIMIT = 3;
endpackage

// File: rtl/spi_bm_baud_calc.sv
module spi_bm_baud_calc #(
  parameter int BAUD_W = 7,
  localparam int CNT_W = BAUD_W + 1
) (
  input  logic [BAUD_W-1:0] baud,
  output logic [CNT_W-1:0]  div_n,
  output logic [CNT_W-1:0]  half_f
);
  import spi_bm_pkg::*;

  // Small baud values collapse to the fastest legal period.
  always_comb begin
    if (baud < BAUD_W'(FIXED_BAUD_LIMIT)) div_n = CNT_W'(MIN_DIV);
    else                                  div_n = {1'b0, baud} + CNT_W'(1);
    half_f = div_n >> 1;
  end
endmodule

// File: rtl/spi_bm_phase_gen.sv
module spi_bm_phase_gen #(
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     active,
  input  logic                     last_bit,
  input  logic [CNT_W-1:0]         div_n,
  input  logic [CNT_W-1:0]         half_f,
  input  logic                     pol,
  input  spi_bm_pkg::phase_mode_e  mode,
  input  logic                     idle_pol,
  output logic                     sclk,
  output logic                     wrap,
  output logic                     finish,
  output logic                     sample
);
  import spi_bm_pkg::*;

  logic [CNT_W-1:0] ph_q, ph_nxt, lead_cnt;
  logic             act_nxt, nonidle, sclk_q;

  // lead_cnt = ceil(N/2): idle-level stretch in delayed timing
  assign lead_cnt = div_n - half_f;
  assign wrap     = active && (ph_q == div_n - CNT_W'(1));
  assign finish   = wrap && last_bit;
  assign sample   = active && ((mode == PH_DELAYED) ? (ph_q == lead_cnt - CNT_W'(1))
                                                    : (ph_q == half_f - CNT_W'(1)));

  always_comb begin
    act_nxt = start | (active & ~finish);
    ph_nxt  = (start | wrap) ? '0 : ph_q + CNT_W'(1);
    nonidle = (mode == PH_DELAYED) ? (ph_nxt >= lead_cnt) : (ph_nxt < half_f);
  end

  // Registered clock output: computed from the next phase so it never glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= act_nxt ? ph_nxt : '0;
      sclk_q <= act_nxt ? (pol ^ nonidle) : idle_pol;
    end
  end

  assign sclk = sclk_q;

  assert_sclk_edge_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && (sclk_q != $past(sclk_q)))
      |-> (ph_q == '0 || ph_q == half_f || ph_q == lead_cnt));

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !start) |=> (sclk_q == $past(idle_pol)));

  assert_finish_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (sclk_q == $past(idle_pol)));
endmodule

// File: rtl/spi_bm_shifter.sv
module spi_bm_shifter #(
  parameter int DATA_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic [DATA_W-1:0] tx_word,
  input  logic [LEN_W-1:0]  len,
  input  logic              shift,
  input  logic              sample,
  input  logic              finish,
  input  logic              miso,
  output logic              mosi,
  output logic [DATA_W-1:0] rx_word
);
  logic [DATA_W-1:0] tx_sr, rx_sr, rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
      rx_sr <= '0;
      rx_q  <= '0;
    end else begin
      if (start)                tx_sr <= tx_word;
      else if (shift && !finish) tx_sr <= {tx_sr[DATA_W-2:0], 1'b0};
      if (start)       rx_sr <= '0;
      else if (sample) rx_sr <= {rx_sr[DATA_W-2:0], miso};
      if (finish)      rx_q  <= rx_sr;
    end
  end

  // The bit under transmission always sits at the selected top position.
  assign mosi    = active & tx_sr[len];
  assign rx_word = rx_q;

  assert_rx_justified_R7: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> ((rx_q >> len) >> 1) == '0);
endmodule

// File: rtl/spi_baud_master.sv
module spi_baud_master #(
  parameter int BAUD_W = 7,
  parameter int DATA_W = 16,
  parameter int LEN_W  = $clog2(DATA_W),
  localparam int CNT_W = BAUD_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              cfg_cpol,
  input  logic              cfg_delayed,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DATA_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  import spi_bm_pkg::*;

  logic [CNT_W-1:0] div_live, half_live, div_q, half_q, div_eff, half_eff;
  logic             pol_q, pol_eff;
  phase_mode_e      mode_q, mode_eff, mode_live;
  logic [LEN_W-1:0] len_q, bit_q;
  logic             busy_q, done_q, accept, wrap, finish, sample, last_bit;

  spi_bm_baud_calc #(.BAUD_W(BAUD_W)) u_baud (
    .baud(cfg_baud), .div_n(div_live), .half_f(half_live)
  );

  assign accept    = tx_valid & ~busy_q;
  assign mode_live = phase_mode_e'(cfg_delayed);
  // Settings come straight from the inputs on the accepting cycle, latched afterwards.
  assign div_eff   = accept ? div_live  : div_q;
  assign half_eff  = accept ? half_live : half_q;
  assign pol_eff   = accept ? cfg_cpol  : pol_q;
  assign mode_eff  = accept ? mode_live : mode_q;
  assign last_bit  = (bit_q == len_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= CNT_W'(MIN_DIV);
      half_q <= CNT_W'(MIN_DIV / 2);
      pol_q  <= 1'b0;
      mode_q <= PH_IMMEDIATE;
      len_q  <= '0;
      bit_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (accept) begin
        div_q  <= div_live;
        half_q <= half_live;
        pol_q  <= cfg_cpol;
        mode_q <= mode_live;
        len_q  <= cfg_len;
        bit_q  <= '0;
      end else if (wrap && !finish) begin
        bit_q <= bit_q + LEN_W'(1);
      end
      busy_q <= accept | (busy_q & ~finish);
      done_q <= finish;
    end
  end

  spi_bm_phase_gen #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(busy_q), .last_bit(last_bit),
    .div_n(div_eff), .half_f(half_eff), .pol(pol_eff), .mode(mode_eff),
    .idle_pol(cfg_cpol), .sclk(sclk), .wrap(wrap), .finish(finish), .sample(sample)
  );

  spi_bm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(accept), .active(busy_q), .tx_word(tx_data),
    .len(len_q), .shift(wrap), .sample(sample), .finish(finish), .miso(miso),
    .mosi(mosi), .rx_word(rx_data)
  );

  assign tx_ready = ~busy_q;
  assign busy     = busy_q;
  assign rx_valid = done_q;

  assert_accept_needs_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(tx_valid));

  assert_bit_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (bit_q <= len_q));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: tb/spi_baud_master_tb.sv
module spi_baud_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BAUD_W = 7;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [BAUD_W-1:0] cfg_baud = '0;
  logic cfg_cpol = 1'b0, cfg_delayed = 1'b0;
  logic [LEN_W-1:0] cfg_len = '0;
  logic tx_valid = 1'b0, tx_ready, rx_valid, busy, sclk, mosi, miso = 1'b0;
  logic [DATA_W-1:0] tx_data = '0, rx_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_baud_master #(.BAUD_W(BAUD_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_baud(cfg_baud), .cfg_cpol(cfg_cpol),
    .cfg_delayed(cfg_delayed), .cfg_len(cfg_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy), .sclk(sclk),
    .mosi(mosi), .miso(miso)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One transfer, checked cycle by cycle against arithmetic from the period N.
  task automatic run_xfer(input int baud, input bit pol, input bit dly, input int len,
                          input logic [DATA_W-1:0] txw, input logic [DATA_W-1:0] pat,
                          input bit scramble, input bit poke);
    int n, f, c, s, total, mask;
    bit clk_ok, mo_ok, bz_ok;
    int ca, ce, ma, me, ba;
    string ctag;
    n = (baud < 3) ? 4 : baud + 1;
    f = n / 2;
    c = n - f;
    s = dly ? c - 1 : f - 1;
    total = n * (len + 1);
    mask = (1 << (len + 1)) - 1;
    clk_ok = 1; mo_ok = 1; bz_ok = 1;
    ca = 0; ce = 0; ma = 0; me = 0; ba = 0;
    ctag = $sformatf("R1 %s R4 %s", (n % 2 == 1) ? "R3" : "R2", dly ? "R6" : "R5");
    @(negedge clk);
    cfg_baud = BAUD_W'(baud); cfg_cpol = pol; cfg_delayed = dly;
    cfg_len = LEN_W'(len); tx_data = txw; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    if (scramble) begin
      cfg_baud = ~BAUD_W'(baud); cfg_cpol = ~pol; cfg_delayed = ~dly; cfg_len = ~LEN_W'(len);
      tx_data = ~txw;
    end
    for (int t = 0; t < total; t++) begin
      int ph, k;
      bit es, em;
      ph = t % n;
      k = t / n;
      es = pol ^ (dly ? (ph >= c) : (ph < f));
      em = txw[len - k];
      if (sclk !== es && clk_ok) begin clk_ok = 0; ca = int'(sclk); ce = int'(es); end
      if (mosi !== em && mo_ok) begin mo_ok = 0; ma = int'(mosi); me = int'(em); end
      if ((busy !== 1'b1 || tx_ready !== 1'b0) && bz_ok) begin bz_ok = 0; ba = t; end
      miso = (ph == s) ? pat[len - k] : ~pat[len - k];
      if (poke) tx_valid = (t >= 1 && t < total - 1);
      @(negedge clk);
    end
    check(clk_ok, scramble ? {ctag, " R10"} : ctag, $sformatf("sclk wave baud %0d", baud), ca, ce);
    check(mo_ok, scramble ? "R7 R10" : "R7", $sformatf("mosi wave baud %0d len %0d", baud, len), ma, me);
    check(bz_ok, "R8", "busy/ready high-low span (first bad cycle)", ba, -1);
    check(busy === 1'b0, "R8", "busy after N*(len+1) cycles", int'(busy), 0);
    check(rx_valid === 1'b1, "R9", "rx_valid at completion", int'(rx_valid), 1);
    check(rx_data === DATA_W'(pat & DATA_W'(mask)), dly ? "R6 R7" : "R5 R7",
          "rx_data", int'(rx_data), int'(pat & DATA_W'(mask)));
    check(sclk === cfg_cpol, "R9", "sclk idle at completion", int'(sclk), int'(cfg_cpol));
    check(mosi === 1'b0, "R8", "mosi idle", int'(mosi), 0);
    @(negedge clk);
    check(rx_valid === 1'b0 && busy === 1'b0, "R8 R9", "single pulse, no restart",
          int'({rx_valid, busy}), 0);
    check(rx_data === DATA_W'(pat & DATA_W'(mask)), "R9", "rx_data held",
          int'(rx_data), int'(pat & DATA_W'(mask)));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && sclk === 1'b0 && mosi === 1'b0 && rx_valid === 1'b0,
          "R11", "control outputs in reset", int'({busy, sclk, mosi, rx_valid}), 0);
    check(rx_data === '0 && tx_ready === 1'b1, "R11", "rx_data/ready in reset",
          int'(rx_data), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && sclk === 1'b0 && tx_ready === 1'b1, "R11", "after reset",
          int'({busy, sclk, tx_ready}), 1);
    cfg_cpol = 1'b1;
    @(negedge clk);
    check(sclk === 1'b1, "R4", "idle level polarity 1", int'(sclk), 1);
    cfg_cpol = 1'b0;
    @(negedge clk);
    check(sclk === 1'b0, "R4", "idle level polarity 0", int'(sclk), 0);

    // Every baud value, every polarity/timing pair, one bit.
    for (int b = 0; b < 128; b++) begin
      for (int m = 0; m < 4; m++) begin
        run_xfer(b, m[0], m[1], 0, DATA_W'(b * 613 + m * 97 + 5),
                 DATA_W'((b * 421) ^ 16'hA5C3 ^ m), (b % 5) == 0, (b % 7) == 0);
      end
    end
    // Every length, odd and even periods, all modes.
    for (int b = 4; b < 6; b++) begin
      for (int l = 0; l < 16; l++) begin
        for (int m = 0; m < 4; m++) begin
          run_xfer(b, m[0], m[1], l, DATA_W'(l * 4099 + b * 31 + m),
                   DATA_W'(16'h5A3C ^ (l * 1237) ^ (m << 3)), (l % 3) == 1, (l % 4) == 2);
        end
      end
    end
    // Short periods, multi-bit words, config scrambled mid-transfer.
    for (int b = 0; b < 13; b++) begin
      for (int m = 0; m < 4; m++) begin
        run_xfer(b, m[0], m[1], 2 + (b % 6), DATA_W'(b * 2711 + m),
                 DATA_W'(16'hC6E1 ^ (b * 151)), 1'b1, 1'b1);
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule